// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This engine walks a circular list of transmit descriptors held in a local descriptor memory. Each entry is two 32-bit words. Word 0 is the control word, with the byte count, the end-of-frame flag, the CRC-suppress flag, the wrap flag and the ownership flag. Word 1 is the byte address of the payload in a separate buffer memory. Software prepares entries and clears their ownership bits. It enables transmission and pulses start. The engine then reads each buffer one byte at a time and presents the bytes on a valid/ready stream. It marks the final byte of a frame. When a descriptor is done, the engine writes its control word back with the ownership bit set.

A frame may span several descriptors. If the engine meets an already-owned descriptor while it is inside a frame, the list has run dry. If the data source reports an underrun, the frame is cut short. In both cases the engine emits one terminating beat flagged as an error and records the cause in a descriptor. Then it stops. A halt request lets the frame in flight complete before the engine goes idle. Every later start continues from the current list position.

Both memories have a one-cycle read latency: read data appears in the cycle after the read strobe. A byte count of zero is not supported.

Top module: `tx_desc_ring_reader`

## Requirements
- R1: After reset, busy_o, tx_valid_o, desc_re_o, desc_we_o and buf_re_o are all low.
- R2: A start pulse is acted on only while tx_en_i is high and the engine is idle. With tx_en_i low the engine stays idle and writes nothing. A start that arrives while busy has no effect.
- R3: If the fetched control word has bit 31 (owned) set and no frame is open, the engine goes idle without emitting a beat and without writing that entry.
- R4: For each entry, the engine streams bits 10:0 (count) bytes, in ascending address order, starting at the byte address in word 1. tx_last_o is high only on the final byte of an entry whose bit 15 (end of frame) is set.
- R5: When an entry finishes, its control word is written back unchanged except that bit 31 is set. The write happens after the entry's final beat is accepted.
- R6: After an entry whose bit 30 is set, the next fetch is entry 0; otherwise the next fetch is the following entry, modulo 16. Every new start resumes at the current position.
- R7: Bit 16 of the first entry of a frame is presented on tx_nocrc_o with every beat of that frame, including a terminating error beat.
- R8: An owned entry met inside an open frame produces one beat with data 0x00, tx_last_o=1 and tx_err_o=1. That entry's control word is written back with bit 27 set, the engine goes idle, and the list position stays on that entry.
- R9: underrun_i high when a byte is due to be fetched produces the same terminating beat. The current entry is then written back with bits 31 and 28 set, the engine goes idle, and the position moves to the next entry.
- R10: A halt_i pulse during a frame lets that frame finish. busy_o stays high until then, and the engine then goes idle without fetching the next entry.
- R11: While tx_valid_o is high and tx_ready_i is low, tx_valid_o, tx_data_o, tx_last_o and tx_err_o hold their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; gates start |
| start_i | input | 1 | Start pulse |
| halt_i | input | 1 | Halt request pulse |
| underrun_i | input | 1 | Data source underrun indication |
| desc_re_o | output | 1 | Descriptor memory read strobe |
| desc_we_o | output | 1 | Descriptor memory write strobe |
| desc_addr_o | output | 5 | Descriptor word address {entry, word} |
| desc_wdata_o | output | 32 | Descriptor write data |
| desc_rdata_i | input | 32 | Descriptor read data, one cycle after the strobe |
| buf_re_o | output | 1 | Buffer memory read strobe |
| buf_addr_o | output | 16 | Buffer byte address |
| buf_rdata_i | input | 8 | Buffer read data, one cycle after the strobe |
| tx_valid_o | output | 1 | Byte beat valid |
| tx_ready_i | input | 1 | Downstream ready |
| tx_data_o | output | 8 | Byte data |
| tx_last_o | output | 1 | Final beat of a frame |
| tx_err_o | output | 1 | Beat terminates an aborted frame |
| tx_nocrc_o | output | 1 | Frame asks for no CRC |
| busy_o | output | 1 | Engine active |

## Verification
Some behaviours are checked on every cycle. These are the stream's hold-under-stall rule, the rule that disabled transmission never wakes the engine, the rule that busy cannot drop in the middle of a frame after a halt, the rule that each write-back follows an accepted final beat, and the rule that the byte cursor never steps past its count. Other behaviours need the bench's scenarios. These are byte order across multi-entry frames, the exact write-back values with bits 27 and 28, wrap-around through bit 30, resumption from the saved position after parking, halt, exhaustion and underrun, and the CRC-suppress sideband.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int unsigned CNT_W  = 11;
  localparam int unsigned LAST_B  = 15;
  localparam int unsigned NOCRC_B = 16;
  localparam int unsigned EXH_B   = 27;
  localparam int unsigned UND_B   = 28;
  localparam int unsigned WRAP_B  = 30;
  localparam int unsigned USED_B  = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTRL, S_WT_CTRL, S_RD_ADDR, S_WT_ADDR,
    S_DRD, S_DWT, S_DOUT, S_ABORT, S_WB
  } state_e;

  typedef enum logic [1:0] {ST_OK, ST_EXH, ST_UND} stat_e;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             wrap_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (adv_i) idx_q <= (wrap_i || idx_q == IDX_W'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/txr_cursor.sv
module txr_cursor #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          final_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      rem_q  <= cnt_i;
    end else if (step_i) begin
      addr_q <= addr_q + 1'b1;
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign addr_o  = addr_q;
  assign final_o = (rem_q == CW'(1));

  // R4
  no_step_past_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> rem_q != '0);
endmodule

// File: rtl/tx_desc_ring_reader.sv
module tx_desc_ring_reader
  import txr_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned BUF_AW = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              start_i,
  input  logic              halt_i,
  input  logic              underrun_i,
  output logic              desc_re_o,
  output logic              desc_we_o,
  output logic [IDX_W:0]    desc_addr_o,
  output logic [31:0]       desc_wdata_o,
  input  logic [31:0]       desc_rdata_i,
  output logic              buf_re_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  output logic              tx_err_o,
  output logic              tx_nocrc_o,
  output logic              busy_o
);
  state_e           state_q, state_d;
  stat_e            stat_q;
  logic [31:0]      ctrl_q;
  logic [7:0]       data_q;
  logic             in_frame_q, halt_pend_q, nocrc_q;
  logic             ptr_adv, cur_load, cur_step, cur_final;
  logic [IDX_W-1:0] idx;
  logic [31:0]      wb_word;

  txr_ring_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk_i, .rst_ni, .adv_i(ptr_adv), .wrap_i(ctrl_q[WRAP_B]), .idx_o(idx)
  );

  txr_cursor #(.AW(BUF_AW), .CW(CNT_W)) i_cur (
    .clk_i, .rst_ni, .load_i(cur_load), .base_i(desc_rdata_i[BUF_AW-1:0]),
    .cnt_i(ctrl_q[CNT_W-1:0]), .step_i(cur_step), .addr_o(buf_addr_o),
    .final_o(cur_final)
  );

  always_comb begin
    wb_word = ctrl_q;
    wb_word[USED_B] = 1'b1;
    if (stat_q == ST_EXH) wb_word[EXH_B] = 1'b1;
    if (stat_q == ST_UND) wb_word[UND_B] = 1'b1;
  end

  always_comb begin
    state_d      = state_q;
    ptr_adv      = 1'b0;
    cur_load     = 1'b0;
    cur_step     = 1'b0;
    desc_re_o    = 1'b0;
    desc_we_o    = 1'b0;
    desc_addr_o  = {idx, 1'b0};
    desc_wdata_o = '0;
    buf_re_o     = 1'b0;
    unique case (state_q)
      S_IDLE:    if (start_i && tx_en_i) state_d = S_RD_CTRL;
      S_RD_CTRL: begin desc_re_o = 1'b1; state_d = S_WT_CTRL; end
      S_WT_CTRL: begin
        if (desc_rdata_i[USED_B]) state_d = in_frame_q ? S_ABORT : S_IDLE;
        else state_d = S_RD_ADDR;
      end
      S_RD_ADDR: begin
        desc_re_o   = 1'b1;
        desc_addr_o = {idx, 1'b1};
        state_d     = S_WT_ADDR;
      end
      S_WT_ADDR: begin cur_load = 1'b1; state_d = S_DRD; end
      S_DRD: begin
        if (underrun_i) state_d = S_ABORT;
        else begin buf_re_o = 1'b1; state_d = S_DWT; end
      end
      S_DWT: state_d = S_DOUT;
      S_DOUT: if (tx_ready_i) begin
        cur_step = 1'b1;
        state_d  = cur_final ? S_WB : S_DRD;
      end
      S_ABORT: if (tx_ready_i) state_d = S_WB;
      S_WB: begin
        desc_we_o    = 1'b1;
        desc_wdata_o = wb_word;
        if (stat_q == ST_EXH) state_d = S_IDLE;  // position stays on the owned entry
        else begin
          ptr_adv = 1'b1;
          if (stat_q == ST_UND) state_d = S_IDLE;
          else if (ctrl_q[LAST_B] && (halt_pend_q || halt_i)) state_d = S_IDLE;
          else state_d = S_RD_CTRL;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      stat_q      <= ST_OK;
      ctrl_q      <= '0;
      data_q      <= '0;
      in_frame_q  <= 1'b0;
      halt_pend_q <= 1'b0;
      nocrc_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      halt_pend_q <= (state_q == S_IDLE) ? 1'b0 : (halt_pend_q | halt_i);
      unique case (state_q)
        S_IDLE: begin stat_q <= ST_OK; in_frame_q <= 1'b0; end
        S_WT_CTRL: begin
          ctrl_q <= desc_rdata_i;
          if (!in_frame_q && !desc_rdata_i[USED_B]) nocrc_q <= desc_rdata_i[NOCRC_B];
          if (in_frame_q && desc_rdata_i[USED_B]) stat_q <= ST_EXH;
        end
        S_DRD:  if (underrun_i) stat_q <= ST_UND;
        S_DWT:  data_q <= buf_rdata_i;
        S_WB:   in_frame_q <= (stat_q == ST_OK) && !ctrl_q[LAST_B];
        default: ;
      endcase
    end
  end

  assign tx_valid_o = (state_q == S_DOUT) || (state_q == S_ABORT);
  assign tx_data_o  = (state_q == S_ABORT) ? 8'h00 : data_q;
  assign tx_last_o  = (state_q == S_ABORT) || ((state_q == S_DOUT) && cur_final && ctrl_q[LAST_B]);
  assign tx_err_o   = (state_q == S_ABORT);
  assign tx_nocrc_o = tx_valid_o && nocrc_q;
  assign busy_o     = (state_q != S_IDLE);

  // R11
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o) && $stable(tx_err_o));

  // R2
  no_wake_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !tx_en_i |=> !busy_o);

  // R5
  wb_after_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |-> $past(tx_valid_o && tx_ready_i));

  // R10
  halt_keeps_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && tx_valid_o && !tx_last_o |=> busy_o);
endmodule

// File: tb/test_tx_desc_ring_reader.sv
module test_tx_desc_ring_reader;
  localparam int DEPTH = 16;
  localparam int BUF_AW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tx_en, start, halt, underrun;
  logic desc_re, desc_we, buf_re;
  logic [4:0] desc_addr;
  logic [31:0] desc_wdata, desc_rdata;
  logic [BUF_AW-1:0] buf_addr;
  logic [7:0] buf_rdata;
  logic tx_valid, tx_ready, tx_last, tx_err, tx_nocrc, busy;
  logic [7:0] tx_data;

  tx_desc_ring_reader #(.DEPTH(DEPTH), .BUF_AW(BUF_AW)) i_tx_desc_ring_reader (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .start_i(start), .halt_i(halt),
    .underrun_i(underrun), .desc_re_o(desc_re), .desc_we_o(desc_we),
    .desc_addr_o(desc_addr), .desc_wdata_o(desc_wdata), .desc_rdata_i(desc_rdata),
    .buf_re_o(buf_re), .buf_addr_o(buf_addr), .buf_rdata_i(buf_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_err_o(tx_err), .tx_nocrc_o(tx_nocrc), .busy_o(busy)
  );

  logic [31:0] dmem [0:2*DEPTH-1];
  logic [7:0]  bmem [0:1023];

  always @(posedge clk) begin
    if (desc_re) desc_rdata <= dmem[desc_addr];
    if (desc_we) dmem[desc_addr] <= desc_wdata;
    if (buf_re)  buf_rdata <= bmem[buf_addr[9:0]];
  end

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R4";
  logic [10:0] expq[$];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(int cnt, bit lst, bit nc, bit wrap, bit used);
    return {used, wrap, 13'b0, nc, lst, 4'b0, 11'(cnt)};
  endfunction

  task automatic set_desc(int i, logic [31:0] c, logic [31:0] a);
    dmem[2*i] = c;
    dmem[2*i+1] = a;
  endtask

  task automatic exp_buf(int a, int n, bit lst, bit nc);
    for (int k = 0; k < n; k++) expq.push_back({nc, 1'b0, lst && (k == n-1), bmem[a+k]});
  endtask

  task automatic exp_abort(bit nc);
    expq.push_back({nc, 1'b1, 1'b1, 8'h00});
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(!busy, req, "busy after run", 32'(busy), 0);
    chk(expq.size() == 0, req, "beats still expected", 32'(expq.size()), 0);
  endtask

  // downstream ready pattern
  initial begin
    int c = 0;
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      c++;
      tx_ready = (c % 5 != 2) && (c % 7 != 3);
    end
  end

  // monitor / scoreboard
  initial begin
    logic [10:0] beat, hold, exp;
    bit stalled = 1'b0;
    forever begin
      @(negedge clk); #8;
      if (rst_n && tx_valid) begin
        beat = {tx_nocrc, tx_err, tx_last, tx_data};
        if (stalled) chk(beat == hold, "R11", "held beat", 32'(beat), 32'(hold));
        if (tx_ready) begin
          stalled = 1'b0;
          if (expq.size() == 0) chk(1'b0, cur_req, "unexpected beat", 32'(beat), 0);
          else begin
            exp = expq.pop_front();
            chk(beat == exp, cur_req, "beat", 32'(beat), 32'(exp));
          end
        end else begin
          stalled = 1'b1;
          hold = beat;
        end
      end else if (rst_n && stalled) begin
        chk(1'b0, "R11", "valid dropped while stalled", 0, 1);
        stalled = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < DEPTH; i++) set_desc(i, cw(0, 0, 0, 0, 1), 0);
    rst_n = 1'b0; tx_en = 1'b0; start = 1'b0; halt = 1'b0; underrun = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !tx_valid, "R1", "busy/valid in reset", {busy, tx_valid}, 0);
    chk(!desc_re && !desc_we && !buf_re, "R1", "ram strobes in reset", {desc_re, desc_we, buf_re}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: disabled start ignored
    set_desc(0, cw(5, 1, 0, 0, 0), 32'h100);
    kick();
    repeat (6) @(negedge clk);
    chk(!busy, "R2", "busy with tx disabled", 32'(busy), 0);
    chk(dmem[0] == cw(5, 1, 0, 0, 0), "R2", "entry0 written while disabled", dmem[0], cw(5, 1, 0, 0, 0));

    // R4 R7 R5 R3: single frame, then two-entry frame with no-CRC, then parking entry
    tx_en = 1'b1;
    cur_req = "R4 R7";
    set_desc(1, cw(3, 0, 1, 0, 0), 32'h200);
    set_desc(2, cw(4, 1, 0, 0, 0), 32'h300);
    set_desc(3, cw(9, 1, 0, 0, 1), 32'h0);
    exp_buf(32'h100, 5, 1, 0);
    exp_buf(32'h200, 3, 0, 1);
    exp_buf(32'h300, 4, 1, 1);
    kick();
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;  // R2: start while busy
    wait_idle("R3");
    chk(dmem[0] == cw(5, 1, 0, 0, 1), "R5", "entry0 writeback", dmem[0], cw(5, 1, 0, 0, 1));
    chk(dmem[2] == cw(3, 0, 1, 0, 1), "R5", "entry1 writeback", dmem[2], cw(3, 0, 1, 0, 1));
    chk(dmem[4] == cw(4, 1, 0, 0, 1), "R5", "entry2 writeback", dmem[4], cw(4, 1, 0, 0, 1));
    chk(dmem[6] == cw(9, 1, 0, 0, 1), "R3", "parking entry", dmem[6], cw(9, 1, 0, 0, 1));

    // R6: resume from the parking position
    cur_req = "R6";
    set_desc(3, cw(2, 1, 0, 0, 0), 32'h050);
    exp_buf(32'h050, 2, 1, 0);
    kick();
    wait_idle("R6");
    chk(dmem[6] == cw(2, 1, 0, 0, 1), "R6", "resumed entry3 writeback", dmem[6], cw(2, 1, 0, 0, 1));

    // R6: wrap bit returns to entry 0
    set_desc(4, cw(1, 1, 0, 1, 0), 32'h060);
    exp_buf(32'h060, 1, 1, 0);
    kick();
    wait_idle("R6");
    set_desc(0, cw(2, 1, 0, 0, 0), 32'h070);
    exp_buf(32'h070, 2, 1, 0);
    kick();
    wait_idle("R6");
    chk(dmem[0] == cw(2, 1, 0, 0, 1), "R6", "entry0 after wrap", dmem[0], cw(2, 1, 0, 0, 1));
    chk(dmem[8] == cw(1, 1, 0, 1, 1), "R5", "wrap entry writeback", dmem[8], cw(1, 1, 0, 1, 1));

    // R8: owned entry inside a frame
    cur_req = "R8";
    set_desc(1, cw(2, 0, 1, 0, 0), 32'h080);
    exp_buf(32'h080, 2, 0, 1);
    exp_abort(1);
    kick();
    wait_idle("R8");
    chk(dmem[2] == cw(2, 0, 1, 0, 1), "R8", "entry1 writeback", dmem[2], cw(2, 0, 1, 0, 1));
    chk(dmem[4] == (cw(4, 1, 0, 0, 1) | 32'h0800_0000), "R8", "exhausted flag", dmem[4],
        cw(4, 1, 0, 0, 1) | 32'h0800_0000);
    set_desc(2, cw(1, 1, 0, 0, 0), 32'h090);
    exp_buf(32'h090, 1, 1, 0);
    kick();
    wait_idle("R8");
    chk(dmem[4] == cw(1, 1, 0, 0, 1), "R8", "position held on exhausted entry", dmem[4], cw(1, 1, 0, 0, 1));

    // R9: underrun
    cur_req = "R9";
    set_desc(3, cw(6, 1, 0, 0, 0), 32'h0A0);
    underrun = 1'b1;
    exp_abort(0);
    kick();
    wait_idle("R9");
    underrun = 1'b0;
    chk(dmem[6] == (cw(6, 1, 0, 0, 1) | 32'h1000_0000), "R9", "underrun flag", dmem[6],
        cw(6, 1, 0, 0, 1) | 32'h1000_0000);
    set_desc(4, cw(1, 1, 0, 0, 0), 32'h0B0);
    exp_buf(32'h0B0, 1, 1, 0);
    kick();
    wait_idle("R9");
    chk(dmem[8] == cw(1, 1, 0, 0, 1), "R9", "position advanced past underrun", dmem[8], cw(1, 1, 0, 0, 1));

    // R10: halt lets the frame finish, next frame waits
    cur_req = "R10";
    set_desc(5, cw(3, 1, 0, 0, 0), 32'h0C0);
    set_desc(6, cw(2, 1, 0, 0, 0), 32'h0D0);
    exp_buf(32'h0C0, 3, 1, 0);
    kick();
    repeat (3) @(negedge clk);
    halt = 1'b1; @(negedge clk); halt = 1'b0;
    chk(busy, "R10", "busy after halt", 32'(busy), 1);
    wait_idle("R10");
    chk(dmem[12] == cw(2, 1, 0, 0, 0), "R10", "next entry untouched", dmem[12], cw(2, 1, 0, 0, 0));
    exp_buf(32'h0D0, 2, 1, 0);
    kick();
    wait_idle("R10");
    chk(dmem[12] == cw(2, 1, 0, 0, 1), "R10", "resumed after halt", dmem[12], cw(2, 1, 0, 0, 1));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule